// File: doc/BRIEF.md
# Fully Associative Address Translation Cache with Flush

This block holds a small set of recently used page-table entries so that a virtual page number can be turned into a physical page number without a page-table access. Every lookup compares the requested virtual page number against all stored tags in parallel. The result comes back on registered outputs one cycle after the request. A miss tells the surrounding walker to fetch the entry and hand it back on the refill port.

Each entry holds a virtual page tag, a physical page number, a valid bit and a dirty bit. A write lookup that hits marks its entry dirty. When a refill displaces a dirty entry, that entry is presented on the eviction outputs so that the page table can record the modified state. A flush input clears every valid bit in one cycle. The flush is raised on a process switch so that one process never reuses the translations of another.

Top module: `tlb_fa`

## Requirements
- R1: After a synchronous reset, all entries are invalid, and `rsp_hit`, `rsp_miss` and `evict_valid` are 0. The first lookup after reset misses.
- R2: A lookup presented in cycle N is answered on the outputs after the clock edge that ends cycle N. If a valid entry holds `lk_vpn`, the answer is `rsp_hit`=1 with that entry's page number. Otherwise it is `rsp_miss`=1 with `rsp_ppn`=0. With no request, both flags are 0.
- R3: A write lookup (`lk_write`=1) that hits sets the entry's dirty bit, and `rsp_dirty` reports the bit after the access. A read hit leaves the dirty bit unchanged.
- R4: While any entry is invalid, a refill with a new tag goes into the lowest-numbered invalid entry. No valid translation is displaced and no eviction is signalled.
- R5: When all entries are valid, a refill with a new tag replaces the entry selected by a round-robin pointer. The pointer is 0 after reset and advances by one, with wrap, only when it is used. A flush does not change it.
- R6: When a refill replaces a valid dirty entry, `evict_valid` pulses for one cycle after that edge, carrying the old tag and page number. Replacing a clean entry raises no pulse.
- R7: A refill whose tag already sits in a valid entry rewrites that entry's page number and sets its dirty bit to `fill_dirty`. No second copy is made and no eviction is signalled.
- R8: A flush invalidates every entry at its clock edge, so all later lookups miss until refills arrive. A flush signals no eviction.
- R9: A refill presented in the same cycle as a flush is dropped.
- R10: A lookup and a refill in the same cycle: the lookup sees the contents from before the refill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| lk_write | input | 1 | Lookup is a write access |
| rsp_hit | output | 1 | Registered: lookup hit |
| rsp_miss | output | 1 | Registered: lookup missed |
| rsp_ppn | output | PPN_W | Registered: physical page number on a hit, else 0 |
| rsp_dirty | output | 1 | Registered: dirty bit of the hit entry after the access |
| fill_valid | input | 1 | Refill entry present |
| fill_vpn | input | VPN_W | Refill virtual page tag |
| fill_ppn | input | PPN_W | Refill physical page number |
| fill_dirty | input | 1 | Refill dirty state |
| flush | input | 1 | Invalidate all entries |
| evict_valid | output | 1 | Registered: a dirty entry was displaced |
| evict_vpn | output | VPN_W | Tag of the displaced entry |
| evict_ppn | output | PPN_W | Page number of the displaced entry |

## Verification
The bench uses a four-entry configuration with a 6-bit tag. It sweeps all 64 tags against the stored set after each phase, which separates exact-match hits from near-miss tags in every entry position. Directed patterns cover filling an empty buffer, filling a full one, rewriting a resident tag, flushing with a refill in the same cycle, and lookups that share a cycle with a refill. Together they tell invalid-first placement from round-robin replacement, and an in-place update from a duplicate entry. A long pseudo-random mix of reads, writes, refills and rare flushes over a small tag pool then exercises dirty tracking and eviction against an arithmetic model.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic [1:0] {
    FILL_NONE   = 2'd0,
    FILL_UPDATE = 2'd1,
    FILL_ALLOC  = 2'd2
  } fill_act_e;
endpackage

// File: rtl/tlb_cam_match.sv
module tlb_cam_match #(
  parameter int ENTRIES = 64,
  parameter int VPN_W   = 20,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0]            valid,
  input  logic [ENTRIES-1:0][VPN_W-1:0] tags,
  input  logic [VPN_W-1:0]              key,
  output logic [ENTRIES-1:0]            match_vec,
  output logic                          hit,
  output logic [IDX_W-1:0]              idx
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match_vec[g] = valid[g] && (tags[g] == key);
  end

  assign hit = |match_vec;

  // One-hot to binary: OR of the set positions.
  always_comb begin
    idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match_vec[i]) idx = idx | IDX_W'(i);
    end
  end
endmodule

// File: rtl/tlb_victim_sel.sv
module tlb_victim_sel #(
  parameter int ENTRIES = 64,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] valid,
  input  logic [IDX_W-1:0]   rr_ptr,
  output logic               any_free,
  output logic [IDX_W-1:0]   victim
);
  logic [IDX_W-1:0] free_idx;

  // The scan runs from the top down, so the lowest free slot wins.
  always_comb begin
    any_free = 1'b0;
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid[i]) begin
        any_free = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
    victim = any_free ? free_idx : rr_ptr;
  end
endmodule

// File: rtl/tlb_fa.sv
module tlb_fa
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 12,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lk_valid,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic             lk_write,
  output logic             rsp_hit,
  output logic             rsp_miss,
  output logic [PPN_W-1:0] rsp_ppn,
  output logic             rsp_dirty,
  input  logic             fill_valid,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic             fill_dirty,
  input  logic             flush,
  output logic             evict_valid,
  output logic [VPN_W-1:0] evict_vpn,
  output logic [PPN_W-1:0] evict_ppn
);
  // Entry storage: tags stay in flops for the parallel compare; page numbers
  // and dirty bits are plain arrays without reset.
  logic [ENTRIES-1:0]            valid_q;
  logic [ENTRIES-1:0][VPN_W-1:0] tag_q;
  logic [PPN_W-1:0]              ppn_mem [ENTRIES];
  logic [ENTRIES-1:0]            dirty_q;
  logic [IDX_W-1:0]              ptr_q;

  logic [ENTRIES-1:0] lk_vec, f_vec;
  logic               lk_m_hit, f_m_hit;
  logic [IDX_W-1:0]   lk_idx, f_idx;
  logic               any_free;
  logic [IDX_W-1:0]   victim;

  tlb_cam_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_lk_match (
    .valid(valid_q), .tags(tag_q), .key(lk_vpn),
    .match_vec(lk_vec), .hit(lk_m_hit), .idx(lk_idx)
  );

  tlb_cam_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_fill_match (
    .valid(valid_q), .tags(tag_q), .key(fill_vpn),
    .match_vec(f_vec), .hit(f_m_hit), .idx(f_idx)
  );

  tlb_victim_sel #(.ENTRIES(ENTRIES)) u_victim (
    .valid(valid_q), .rr_ptr(ptr_q), .any_free(any_free), .victim(victim)
  );

  logic             lk_hit_now, wr_hit;
  fill_act_e        act;
  logic [IDX_W-1:0] tgt;
  logic             tgt_dirty, evict_now, tgt_wr;

  always_comb begin
    lk_hit_now = lk_valid && lk_m_hit;
    wr_hit     = lk_hit_now && lk_write;
    if (flush || !fill_valid) act = FILL_NONE;
    else if (f_m_hit)         act = FILL_UPDATE;
    else                      act = FILL_ALLOC;
    tgt       = (act == FILL_UPDATE) ? f_idx : victim;
    tgt_wr    = wr_hit && (lk_idx == tgt);
    tgt_dirty = dirty_q[tgt] || tgt_wr;
    evict_now = (act == FILL_ALLOC) && valid_q[tgt] && tgt_dirty;
  end

  // Control state and registered outputs.
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q     <= '0;
      ptr_q       <= '0;
      rsp_hit     <= 1'b0;
      rsp_miss    <= 1'b0;
      rsp_ppn     <= '0;
      rsp_dirty   <= 1'b0;
      evict_valid <= 1'b0;
      evict_vpn   <= '0;
      evict_ppn   <= '0;
    end else begin
      rsp_hit     <= lk_hit_now;
      rsp_miss    <= lk_valid && !lk_m_hit;
      rsp_ppn     <= lk_hit_now ? ppn_mem[lk_idx] : '0;
      rsp_dirty   <= lk_hit_now && (dirty_q[lk_idx] || lk_write);
      evict_valid <= evict_now;
      evict_vpn   <= evict_now ? tag_q[tgt] : '0;
      evict_ppn   <= evict_now ? ppn_mem[tgt] : '0;
      if (flush) begin
        valid_q <= '0;
      end else if (act != FILL_NONE) begin
        valid_q[tgt] <= 1'b1;
        if (act == FILL_ALLOC && !any_free)
          ptr_q <= (ptr_q == IDX_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
      end
    end
  end

  // Entry payload, written like a RAM (no reset; valid_q gates it).
  always_ff @(posedge clk) begin
    if (!rst && !flush) begin
      if (wr_hit) dirty_q[lk_idx] <= 1'b1;
      if (act != FILL_NONE) begin
        tag_q[tgt]   <= fill_vpn;
        ppn_mem[tgt] <= fill_ppn;
        dirty_q[tgt] <= fill_dirty || ((act == FILL_UPDATE) && tgt_wr);
      end
    end
  end

  // R7: no tag is ever held twice.
  a_r7_unique_tags: assert property (@(posedge clk) disable iff (rst)
    $onehot0(lk_vec) && $onehot0(f_vec));

  // R2: exactly one answer per request, none without a request.
  a_r2_rsp_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(rsp_hit && rsp_miss));
  a_r2_rsp_follows: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> (rsp_hit || rsp_miss));
  a_r2_rsp_idle: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> (!rsp_hit && !rsp_miss));

  // R4: a free slot is preferred over a live one.
  a_r4_free_first: assert property (@(posedge clk) disable iff (rst)
    (act == FILL_ALLOC && any_free) |-> !valid_q[victim]);

  // R5: the pointer only moves on a refill.
  a_r5_ptr_idle: assert property (@(posedge clk) disable iff (rst)
    (!fill_valid || flush) |=> $stable(ptr_q));

  // R8 / R9: a flush empties the buffer and drops any refill.
  a_r8_flush_clears: assert property (@(posedge clk) disable iff (rst)
    flush |=> (valid_q == '0));
  a_r9_flush_no_evict: assert property (@(posedge clk) disable iff (rst)
    flush |=> !evict_valid);
endmodule

// File: tb/tlb_fa_bench.sv
module tlb_fa_bench;
  localparam int E  = 4;
  localparam int VW = 6;
  localparam int PW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic          lk_valid = 0, lk_write = 0, fill_valid = 0, fill_dirty = 0, flush = 0;
  logic [VW-1:0] lk_vpn = '0, fill_vpn = '0;
  logic [PW-1:0] fill_ppn = '0;
  logic          rsp_hit, rsp_miss, rsp_dirty, evict_valid;
  logic [PW-1:0] rsp_ppn, evict_ppn;
  logic [VW-1:0] evict_vpn;

  tlb_fa #(.ENTRIES(E), .VPN_W(VW), .PPN_W(PW)) u_tlb_fa (
    .clk(clk), .rst(rst),
    .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_write(lk_write),
    .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_ppn(rsp_ppn), .rsp_dirty(rsp_dirty),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
    .fill_dirty(fill_dirty), .flush(flush),
    .evict_valid(evict_valid), .evict_vpn(evict_vpn), .evict_ppn(evict_ppn)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // Model of the requirements.
  logic          mv [E];
  logic [VW-1:0] mvpn [E];
  logic [PW-1:0] mppn [E];
  logic          md [E];
  int            mptr = 0;

  function automatic logic [PW-1:0] pg(input int v);
    return PW'((v * 5 + 3) % 16);
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic lv, input logic [VW-1:0] lvpn, input logic lw,
                      input logic fv, input logic [VW-1:0] fvpn, input logic [PW-1:0] fppn,
                      input logic fd, input logic fl, input string req);
    int li, fi, v;
    logic [15:0] exp_rsp, exp_ev;
    @(negedge clk);
    lk_valid = lv; lk_vpn = lvpn; lk_write = lw;
    fill_valid = fv; fill_vpn = fvpn; fill_ppn = fppn; fill_dirty = fd; flush = fl;
    li = -1;
    for (int i = 0; i < E; i++) if (mv[i] && mvpn[i] == lvpn) li = i;
    exp_rsp = '0;
    if (lv) exp_rsp = (li >= 0) ? {9'd0, 1'b1, 1'b0, mppn[li], md[li] | lw}
                                : {9'd0, 1'b0, 1'b1, 4'd0, 1'b0};
    exp_ev = '0;
    if (fl) begin
      for (int i = 0; i < E; i++) mv[i] = 1'b0;
    end else begin
      if (lv && lw && li >= 0) md[li] = 1'b1;
      if (fv) begin
        fi = -1;
        for (int i = 0; i < E; i++) if (mv[i] && mvpn[i] == fvpn) fi = i;
        if (fi >= 0) begin
          mppn[fi] = fppn;
          md[fi]   = fd | (lv && lw && li == fi);
        end else begin
          v = -1;
          for (int i = E - 1; i >= 0; i--) if (!mv[i]) v = i;
          if (v < 0) begin
            v = mptr;
            mptr = (mptr + 1) % E;
          end
          if (mv[v] && md[v]) exp_ev = {5'd0, 1'b1, mvpn[v], mppn[v]};
          mv[v] = 1'b1; mvpn[v] = fvpn; mppn[v] = fppn; md[v] = fd;
        end
      end
    end
    @(posedge clk);
    #1;
    chk(req, {9'd0, rsp_hit, rsp_miss, rsp_ppn, rsp_dirty}, exp_rsp);
    chk(req, {5'd0, evict_valid, evict_vpn, evict_ppn}, exp_ev);
  endtask

  task automatic look(input int v, input logic w, input string req);
    step(1'b1, VW'(v), w, 1'b0, '0, '0, 1'b0, 1'b0, req);
  endtask

  task automatic fill(input int v, input logic [PW-1:0] p, input logic d, input string req);
    step(1'b0, '0, 1'b0, 1'b1, VW'(v), p, d, 1'b0, req);
  endtask

  task automatic sweep(input string req);
    for (int v = 0; v < 64; v++) look(v, 1'b0, req);
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    if (!done) begin
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    for (int i = 0; i < E; i++) begin mv[i] = 0; mvpn[i] = '0; mppn[i] = '0; md[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    chk("R1 reset outputs", {13'd0, rsp_hit, rsp_miss, evict_valid}, 16'd0);
    look(0, 1'b0, "R1 first lookup");

    // Fill an empty buffer; the lookup in the same cycle sees the old contents.
    step(1'b1, 6'd10, 1'b0, 1'b1, 6'd10, pg(10), 1'b0, 1'b0, "R10 lookup with refill");
    look(10, 1'b0, "R10 lookup after refill");
    fill(20, pg(20), 1'b0, "R4");
    fill(30, pg(30), 1'b0, "R4");
    fill(40, pg(40), 1'b0, "R4");
    sweep("R2");

    look(20, 1'b1, "R3 write hit");
    look(20, 1'b0, "R3 dirty kept");
    look(10, 1'b0, "R3 read hit clean");

    fill(50, pg(50), 1'b0, "R5 clean victim");
    fill(60, pg(60), 1'b0, "R6 dirty victim");
    sweep("R5");

    fill(30, 4'd9, 1'b1, "R7 update in place");
    look(30, 1'b0, "R7 new page");
    fill(11, pg(11), 1'b0, "R7 single copy evicted");

    step(1'b0, '0, 1'b0, 1'b1, 6'd12, pg(12), 1'b1, 1'b1, "R9 flush with refill");
    sweep("R8");

    fill(1, pg(1), 1'b1, "R4 after flush");
    fill(2, pg(2), 1'b0, "R4 after flush");
    fill(3, pg(3), 1'b1, "R4 after flush");
    fill(4, pg(4), 1'b0, "R4 after flush");
    fill(5, pg(5), 1'b0, "R5 pointer kept");
    sweep("R2 R5");

    seed = 32'h1234_5678;
    for (int n = 0; n < 400; n++) begin
      logic [VW-1:0] a, b;
      seed = seed * 32'd1103515245 + 32'd12345;
      a = VW'(seed[18:16]);
      b = VW'(seed[22:20]);
      step(seed[24], a, seed[25], seed[26], b, seed[30:27], seed[31],
           (seed[15:11] == 5'd0), "R2/R3/R5/R6/R7 mix");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule